// File: doc/BRIEF.md
# MDIO Management Access Controller

This block lets software reach the management registers of an external Ethernet PHY through two small registers. Software writes one 32-bit command word that holds the PHY address, the register number, a read/write selector and, for writes, 16 bits of data. The block then generates the management clock and shifts a complete clause-22 frame out on the data line. For a read, it turns the line around and shifts the PHY's reply back in.

The same command word also serves as the status word. A busy flag is set for as long as the frame is in progress. When a read finishes, a read-valid flag is set and the returned 16 bits replace the low half of the word. A second register holds a default 5-bit PHY address for software's own use. The management clock is the system clock divided by a parameter. With the default setting and a 200 MHz system clock, the management clock runs at 2.5 MHz.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the command/status word reads 0, the PHY-address register reads `PHY_ADDR_RST`, the management clock is low and the data line is not driven (`mdio_oe` = 0).
- R2: A write with `reg_sel` = 0 while idle is accepted. In the next cycle, bit 28 (busy) of the status word reads 1 and bit 27 (read-valid) reads 0. Bits [15:0] hold the write data, [20:16] the PHY address, [25:21] the register number, and bit 26 the operation (1 = read, 0 = write).
- R3: A command write that arrives while busy is 1 is ignored. The frame on the line and the status word fields are unchanged by it.
- R4: A write access sends 64 bits, MSB first, with `mdio_oe` held at 1 throughout: 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10, then bits [15:0] of the command word.
- R5: A read access drives 32 ones, start bits 01, opcode 10, the PHY address and the register number. It releases the line (`mdio_oe` = 0) from the first turnaround bit (frame bit 46) to the end of the frame.
- R6: On a read, the 16 data bits are sampled on management-clock rising edges, MSB first. When the read completes, busy clears, read-valid sets, and the sampled data appears in bits [15:0].
- R7: Busy stays 1 for exactly 128 × `DIV_HALF` system cycles after acceptance. The management clock toggles every `DIV_HALF` cycles.
- R8: A write with `reg_sel` = 1 stores `reg_wdata[4:0]` into the PHY-address register. Its other bits are ignored and read back as 0. This write does not affect the command word.
- R9: After a write access completes, read-valid stays 0 and bits [15:0] still hold the written data.
- R10: Outside an access, the management clock stays low and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command word, 1 the PHY-address register |
| reg_wdata | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command/status word |
| phy_addr | output | 5 | Default PHY-address register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench models the PHY and captures every bit on each rising clock edge, so any error in the frame shows up. Such errors include a swapped opcode, a misplaced address field, or an off-by-one in the bit counter. A command injected mid-access checks the busy lock: a design that accepted it would corrupt the captured frame or the fields read back. The bench returns read data with both end bits set and checks the exact busy duration. A design that released the line one bit late, lost the first or last sampled bit, or ran an extra half-period would fail these checks. PHY-address writes with high bits set confirm that only the low five bits are kept.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_HALF = 40,
  parameter logic [4:0] PHY_ADDR_RST = 5'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_rdata,
  output logic [4:0]  phy_addr,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW = $clog2(DIV_HALF + 1);
  localparam int LAST_IDX = 63;
  localparam int TA_IDX = 46;
  localparam int DATA_IDX = 48;

  logic          busy, rvalid, op_rd;
  logic [4:0]    reg_num, phy_num;
  logic [15:0]   data16, rsh;
  logic [63:0]   sh;
  logic [5:0]    idx;
  logic [CW-1:0] cnt;
  logic          oe;

  wire accept = reg_wr && !reg_sel && !busy;
  wire tick   = (cnt == CW'(DIV_HALF - 1));

  assign cmd_rdata = {3'b000, busy, rvalid, op_rd, reg_num, phy_num, data16};
  assign mdio_o    = sh[63];
  assign mdio_oe   = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rvalid <= 1'b0; op_rd <= 1'b0;
      reg_num <= '0; phy_num <= '0; data16 <= '0; rsh <= '0;
      sh <= '0; idx <= '0; cnt <= '0; mdc <= 1'b0; oe <= 1'b0;
    end else if (accept) begin
      busy    <= 1'b1;
      rvalid  <= 1'b0;
      op_rd   <= reg_wdata[26];
      reg_num <= reg_wdata[25:21];
      phy_num <= reg_wdata[20:16];
      data16  <= reg_wdata[15:0];
      sh      <= {32'hFFFF_FFFF, 2'b01, reg_wdata[26] ? 2'b10 : 2'b01,
                  reg_wdata[20:16], reg_wdata[25:21], 2'b10, reg_wdata[15:0]};
      idx <= '0; cnt <= '0; mdc <= 1'b0; oe <= 1'b1;
    end else if (busy) begin
      if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        mdc <= ~mdc;
        if (!mdc) begin
          if (op_rd && idx >= 6'(DATA_IDX)) rsh <= {rsh[14:0], mdio_i};
        end else if (idx == 6'(LAST_IDX)) begin
          busy <= 1'b0;
          oe   <= 1'b0;
          if (op_rd) begin
            rvalid <= 1'b1;
            data16 <= rsh;
          end
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[62:0], 1'b0};
          if (op_rd && idx >= 6'(TA_IDX - 1)) oe <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phy_addr <= PHY_ADDR_RST;
    else if (reg_wr && reg_sel) phy_addr <= reg_wdata[4:0];
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic [31:0] cmd_rdata,
  input logic [4:0]  phy_addr,
  input logic        mdc,
  input logic        mdio_oe
);
  wire busy   = cmd_rdata[28];
  wire rvalid = cmd_rdata[27];

  // R2
  busy_rise_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && !reg_sel));

  // R3
  fields_locked_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_rdata[26:16]));

  // R6
  rvalid_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $fell(busy));

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> busy);

  // R10
  line_released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);

  // R8
  phy_addr_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phy_addr) |-> $past(reg_wr && reg_sel));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .cmd_rdata(cmd_rdata), .phy_addr(phy_addr), .mdc(mdc), .mdio_oe(mdio_oe)
);

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  localparam int DIV_HALF = 5;
  localparam logic [4:0] PA_RST = 5'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [4:0] phy_addr;
  logic mdc, mdio_o, mdio_oe;
  logic mdio_i = 1'b1;

  int checks = 0, fails = 0, cyc = 0, rc = 0;
  logic [63:0] frame = '0, oev = '0;
  logic [15:0] reply = '0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF), .PHY_ADDR_RST(PA_RST)) i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_rdata(cmd_rdata), .phy_addr(phy_addr),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always @(posedge mdc) begin
    frame = {frame[62:0], mdio_o};
    oev   = {oev[62:0], mdio_oe};
    rc    = rc + 1;
  end

  always @(negedge mdc) begin
    if (rc == 47) mdio_i = 1'b0;
    else if (rc >= 48 && rc <= 63) mdio_i = reply[63 - rc];
    else mdio_i = 1'b1;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  task automatic wr_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] d, input logic [15:0] rep, input bit inject);
    int cycles;
    logic [63:0] ef;
    reply = rep; rc = 0;
    wr_reg(1'b0, {5'b0, rd, ra, pa, d});
    chk(cmd_rdata[28] == 1'b1 && cmd_rdata[27] == 1'b0, "R2 busy set, rvalid clear",
        64'(cmd_rdata), 64'({3'b0, 1'b1, 1'b0, rd, ra, pa, d}));
    chk(cmd_rdata[26:0] == {rd, ra, pa, d}, "R2 fields", 64'(cmd_rdata[26:0]), 64'({rd, ra, pa, d}));
    cycles = 0;
    while (cmd_rdata[28]) begin
      cycles++;
      if (inject && cycles == 50) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ~{5'b0, rd, ra, pa, d};
      end else reg_wr = 1'b0;
      @(negedge clk);
    end
    reg_wr = 1'b0;
    chk(cycles == 128 * DIV_HALF, "R7 busy duration", 64'(cycles), 64'(128 * DIV_HALF));
    chk(rc == 64, "R7 mdc rising edges", 64'(rc), 64'd64);
    ef = exp_frame(rd, pa, ra, d);
    if (rd) begin
      chk(frame[63:18] == ef[63:18], "R5 read header", frame, ef);
      chk(oev == {{46{1'b1}}, 18'b0}, "R5 line release", oev, {{46{1'b1}}, 18'b0});
      chk(cmd_rdata == {3'b0, 1'b0, 1'b1, 1'b1, ra, pa, rep}, "R6 read result",
          64'(cmd_rdata), 64'({3'b0, 1'b0, 1'b1, 1'b1, ra, pa, rep}));
    end else begin
      chk(frame == ef, "R4 write frame", frame, ef);
      chk(oev == '1, "R4 driven throughout", oev, '1);
      chk(cmd_rdata == {3'b0, 1'b0, 1'b0, 1'b0, ra, pa, d}, "R9 write result",
          64'(cmd_rdata), 64'({3'b0, 1'b0, 1'b0, 1'b0, ra, pa, d}));
    end
    if (inject) chk(cmd_rdata[25:16] == {ra, pa}, "R3 injected command ignored",
                    64'(cmd_rdata[25:16]), 64'({ra, pa}));
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle line", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cmd_rdata == 32'd0, "R1 status word", 64'(cmd_rdata), 64'd0);
    chk(phy_addr == PA_RST, "R1 phy addr", 64'(phy_addr), 64'(PA_RST));
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 line idle", 64'({mdc, mdio_oe}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    wr_reg(1'b1, 32'hFFFF_FFE3);
    chk(phy_addr == 5'd3, "R8 low bits only", 64'(phy_addr), 64'd3);
    chk(cmd_rdata == 32'd0, "R8 command untouched", 64'(cmd_rdata), 64'd0);
    wr_reg(1'b1, 32'h0000_001F);
    chk(phy_addr == 5'd31, "R8 max address", 64'(phy_addr), 64'd31);

    run_cmd(1'b0, 5'd31, 5'd31, 16'hFFFF, 16'h0, 1'b0);
    run_cmd(1'b0, 5'd0, 5'd0, 16'h0000, 16'h0, 1'b0);
    run_cmd(1'b1, 5'd1, 5'd2, 16'h0000, 16'h8001, 1'b0);
    run_cmd(1'b1, 5'd31, 5'd0, 16'hFFFF, 16'hA5C3, 1'b1);
    run_cmd(1'b0, 5'd17, 5'd9, 16'h1234, 16'h0, 1'b1);

    for (int k = 0; k < 12; k++) begin
      logic [31:0] r;
      r = $urandom;
      run_cmd(r[26], r[20:16], r[25:21], r[15:0], 16'($urandom), r[27]);
    end

    chk(phy_addr == 5'd31, "R8 unchanged by commands", 64'(phy_addr), 64'd31);
    summary();
  end
endmodule